// File: doc/BRIEF.md
# Paged Byte-Write Controller for a 2K x 8 Nonvolatile Array

This block sits between a host that drives memory-style strobes (active-low chip select, output enable and write enable) and a 2048-byte array model. Each write strobe deposits one byte into a 64-byte staging latch. Every accepted byte restarts an inactivity timer. When the timer runs a full window with no new byte, the controller starts an internally timed programming phase. At the end of that phase it copies the staged bytes into the array.

A burst is a run of bytes that all share address bits 10:6. If any byte in a burst carries a different page number, the whole burst is dropped when the window closes and nothing is programmed. A lone byte is simply a burst of length one. The programming phase cannot be interrupted. While it runs, `busy` is high, reads return no valid data, and write strobes are ignored.

All pins are sampled on the rising clock edge. The strobe pins are plain control inputs with no valid/ready handshake, so they exert no back-pressure. A host that needs flow control watches `busy`: bytes strobed while it is high are lost. The read port is a qualified output. `rd_valid` marks the cycles in which `rdata` is meaningful, and the port has no ready input because reads carry no state.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy` is 0 and every array byte reads as 8'hFF.
- R2: `rd_valid` is 1 exactly when `cs_n`=0, `oe_n`=0, `we_n`=1 and `busy`=0. While it is 1, `rdata` is the array byte at `addr`.
- R3: A write strobe is the span of cycles in which `cs_n`=0, `we_n`=0 and `oe_n`=1. The address is taken from the first cycle of the span and the data from its last cycle.
- R4: A single strobed byte is written to its array location once the load window and the program phase have completed.
- R5: Several bytes strobed into one page (same `addr[10:6]`, offset `addr[5:0]`) are committed together in one program phase. Bytes of that page that were not strobed keep their values.
- R6: If a burst contains bytes whose `addr[10:6]` differ, nothing from the burst is written and `busy` never rises for it.
- R7: Programming starts only after LOAD_WIN clock cycles pass with no new byte. Each new byte restarts that window.
- R8: Once raised, `busy` stays high for exactly PROG_CYCLES clock cycles.
- R9: While `busy` is high, write strobes have no effect on the array and `rd_valid` is 0.
- R10: A strobe with `oe_n`=0 is not a write and changes no array byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 11 | Byte address: bits 10:6 are the page, bits 5:0 the offset |
| wdata | input | 8 | Write data |
| cs_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| busy | output | 1 | High during the internal program phase |
| rd_valid | output | 1 | Read data qualifier |
| rdata | output | 8 | Read data |

## Verification
The assertions assume that the strobe pins are synchronous to `clk` and that a strobe lasts at least one full cycle. Under that assumption, the sampler's end-of-strobe pulse is a single cycle and cannot coincide with a new strobe start. The stimulus changes pins only on the falling clock edge and keeps every strobe at least one cycle long. It separates strobes by at least one idle cycle and opens a strobe during `busy` only when testing the ignore rule.

// File: rtl/epw_pkg.sv
package epw_pkg;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int OFF_W  = 6;
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int ARR_DEPTH  = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] ERASED = '1;
endpackage

// File: rtl/epw_strobe.sv
module epw_strobe
  import epw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  output logic              byte_vld,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [DATA_W-1:0] byte_data
);
  logic wr_act, act_q;
  assign wr_act = ~cs_n & ~we_n & oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      byte_vld  <= 1'b0;
      byte_addr <= '0;
      byte_data <= '0;
    end else begin
      act_q    <= wr_act;
      byte_vld <= act_q & ~wr_act;
      if (wr_act && !act_q) byte_addr <= addr;
      if (wr_act) byte_data <= wdata;
    end
  end

  // R3
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
endmodule

// File: rtl/epw_page_buf.sv
module epw_page_buf
  import epw_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               byte_acc,
  input  logic [ADDR_W-1:0]                  byte_addr,
  input  logic [DATA_W-1:0]                  byte_data,
  input  logic                               clear,
  output logic                               loaded,
  output logic                               page_bad,
  output logic [PAGE_W-1:0]                  tag,
  output logic [PAGE_BYTES-1:0]              mask,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]  pdata
);
  logic [PAGE_W-1:0] in_page;
  logic [OFF_W-1:0]  in_off;
  assign in_page = byte_addr[ADDR_W-1:OFF_W];
  assign in_off  = byte_addr[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded   <= 1'b0;
      page_bad <= 1'b0;
      tag      <= '0;
      mask     <= '0;
    end else if (clear) begin
      loaded   <= 1'b0;
      page_bad <= 1'b0;
      mask     <= '0;
    end else if (byte_acc) begin
      mask[in_off] <= 1'b1;
      if (!loaded) begin
        loaded <= 1'b1;
        tag    <= in_page;
      end else if (in_page != tag) begin
        page_bad <= 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pdata[g] <= '0;
        else if (byte_acc && !clear && in_off == OFF_W'(g)) pdata[g] <= byte_data;
      end
    end
  endgenerate

  // R5
  first_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_acc && !clear && !loaded) |=> (loaded && tag == $past(in_page)));
endmodule

// File: rtl/epw_sequencer.sv
module epw_sequencer #(
  parameter int LOAD_WIN    = 64,
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_vld,
  input  logic loaded,
  input  logic page_bad,
  output logic byte_acc,
  output logic start_prog,
  output logic discard,
  output logic prog_done,
  output logic busy
);
  localparam int IW = $clog2(LOAD_WIN + 1);
  localparam int PW = $clog2(PROG_CYCLES + 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(LOAD_WIN - 1);
  localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYCLES - 1);

  logic [IW-1:0] idle_cnt;
  logic [PW-1:0] prog_cnt;
  logic expire;

  assign byte_acc   = byte_vld & ~busy;
  assign expire     = loaded & ~busy & ~byte_acc & (idle_cnt == IDLE_LAST);
  assign start_prog = expire & ~page_bad;
  assign discard    = expire & page_bad;
  assign prog_done  = busy & (prog_cnt == PROG_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      prog_cnt <= '0;
      busy     <= 1'b0;
    end else begin
      if (byte_acc || !loaded || expire) idle_cnt <= '0;
      else if (!busy) idle_cnt <= idle_cnt + 1'b1;
      if (start_prog) begin
        busy     <= 1'b1;
        prog_cnt <= '0;
      end else if (prog_done) begin
        busy <= 1'b0;
      end else if (busy) begin
        prog_cnt <= prog_cnt + 1'b1;
      end
    end
  end

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_done) |=> busy);
  // R7
  window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !busy) |=> !busy);
  // R6
  bad_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && page_bad) |-> !start_prog);
endmodule

// File: rtl/epw_array.sv
module epw_array
  import epw_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               commit,
  input  logic [PAGE_W-1:0]                  tag,
  input  logic [PAGE_BYTES-1:0]              mask,
  input  logic [PAGE_BYTES-1:0][DATA_W-1:0]  pdata,
  input  logic [ADDR_W-1:0]                  raddr,
  output logic [DATA_W-1:0]                  rdata
);
  logic [DATA_W-1:0] mem [ARR_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARR_DEPTH; i++) mem[i] <= ERASED;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (mask[i]) mem[{tag, OFF_W'(i)}] <= pdata[i];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import epw_pkg::*;
#(
  parameter int LOAD_WIN    = 64,
  parameter int PROG_CYCLES = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [10:0] addr,
  input  logic [7:0]  wdata,
  input  logic        cs_n,
  input  logic        oe_n,
  input  logic        we_n,
  output logic        busy,
  output logic        rd_valid,
  output logic [7:0]  rdata
);
  logic                              byte_vld, byte_acc, start_prog, discard, prog_done;
  logic                              loaded, page_bad;
  logic [ADDR_W-1:0]                 byte_addr;
  logic [DATA_W-1:0]                 byte_data;
  logic [PAGE_W-1:0]                 tag;
  logic [PAGE_BYTES-1:0]             mask;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] pdata;

  epw_strobe u_strobe (
    .clk, .rst_n, .addr, .wdata, .cs_n, .oe_n, .we_n,
    .byte_vld, .byte_addr, .byte_data
  );

  epw_page_buf u_buf (
    .clk, .rst_n, .byte_acc, .byte_addr, .byte_data,
    .clear(discard | prog_done), .loaded, .page_bad, .tag, .mask, .pdata
  );

  epw_sequencer #(.LOAD_WIN(LOAD_WIN), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk, .rst_n, .byte_vld, .loaded, .page_bad,
    .byte_acc, .start_prog, .discard, .prog_done, .busy
  );

  epw_array u_arr (
    .clk, .rst_n, .commit(prog_done), .tag, .mask, .pdata,
    .raddr(addr), .rdata
  );

  assign rd_valid = ~cs_n & ~oe_n & we_n & ~busy;

  // R9
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_done) |=> $stable(mask));
  // R2
  read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_valid);
endmodule

// File: tb/eeprom_page_writer_bench.sv
module eeprom_page_writer_bench;
  localparam int CLK_P = 10;
  localparam int WIN   = 20;
  localparam int PROG  = 30;
  localparam int NV    = 6;
  localparam logic [18:0] VEC [NV] = '{
    {11'h000, 8'h3C}, {11'h7FF, 8'h00}, {11'h555, 8'hAA},
    {11'h2AA, 8'h55}, {11'h040, 8'h81}, {11'h13F, 8'h7E}
  };

  logic clk = 0, rst_n = 0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic cs_n = 1, oe_n = 1, we_n = 1;
  logic busy, rd_valid;
  logic [7:0] rdata;
  int n_chk = 0, n_bad = 0;

  eeprom_page_writer #(.LOAD_WIN(WIN), .PROG_CYCLES(PROG)) u_eeprom_page_writer (
    .clk, .rst_n, .addr, .wdata, .cs_n, .oe_n, .we_n, .busy, .rd_valid, .rdata
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_byte(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; cs_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk);
    @(negedge clk);
    cs_n = 1; we_n = 1;
  endtask

  task automatic read_chk(input string req, input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; cs_n = 0; oe_n = 0; we_n = 1;
    #1;
    check(req, rd_valid, 1);
    check(req, rdata, d);
    cs_n = 1; oe_n = 1;
  endtask

  // waits for busy to rise then returns how many cycles it stayed high (-1 if never)
  task automatic wait_prog(output int len);
    int seen = 0;
    len = -1;
    for (int i = 0; i < WIN + 20 && !seen; i++) begin
      @(negedge clk);
      if (busy) seen = 1;
    end
    if (seen) begin
      len = 0;
      while (busy && len < PROG + 10) begin
        len++;
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int len;
    int rose;
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset state
    check("R1", busy, 0);
    read_chk("R1", 11'h000, 8'hFF);
    read_chk("R1", 11'h7FF, 8'hFF);

    // R4 / R8 / R2 vector walk
    for (int v = 0; v < NV; v++) begin
      write_byte(VEC[v][18:8], VEC[v][7:0]);
      wait_prog(len);
      check("R8", len, PROG);
      read_chk("R4", VEC[v][18:8], VEC[v][7:0]);
    end

    // R2 no read when chip select is high
    @(negedge clk); addr = 11'h000; cs_n = 1; oe_n = 0; we_n = 1; #1;
    check("R2", rd_valid, 0);
    oe_n = 1;

    // R5 page burst, untouched bytes keep their value
    write_byte(11'h1C1, 8'h11);
    idle(2);
    write_byte(11'h1C5, 8'h22);
    idle(2);
    write_byte(11'h1FF, 8'h33);
    wait_prog(len);
    check("R5", len, PROG);
    read_chk("R5", 11'h1C1, 8'h11);
    read_chk("R5", 11'h1C5, 8'h22);
    read_chk("R5", 11'h1FF, 8'h33);
    read_chk("R5", 11'h1C2, 8'hFF);

    // R6 mixed page burst is discarded
    write_byte(11'h080, 8'h12);
    idle(2);
    write_byte(11'h0C0, 8'h34);
    rose = 0;
    for (int i = 0; i < WIN + PROG + 10; i++) begin
      @(negedge clk);
      if (busy) rose = 1;
    end
    check("R6", rose, 0);
    read_chk("R6", 11'h080, 8'hFF);
    read_chk("R6", 11'h0C0, 8'hFF);

    // R7 window restarts on each byte
    rose = 0;
    for (int k = 0; k < 4; k++) begin
      write_byte(11'h240 + 11'(k), 8'hA0 + 8'(k));
      for (int i = 0; i < WIN - 8; i++) begin
        @(negedge clk);
        if (busy) rose = 1;
      end
    end
    check("R7", rose, 0);
    wait_prog(len);
    check("R7", len, PROG);
    read_chk("R7", 11'h243, 8'hA3);
    read_chk("R7", 11'h240, 8'hA0);

    // R3 address from first strobe cycle, data from last
    @(negedge clk);
    addr = 11'h300; wdata = 8'h01; cs_n = 0; we_n = 0;
    @(negedge clk); addr = 11'h301; wdata = 8'h02;
    @(negedge clk); wdata = 8'h03;
    @(negedge clk); cs_n = 1; we_n = 1;
    wait_prog(len);
    read_chk("R3", 11'h300, 8'h03);
    read_chk("R3", 11'h301, 8'hFF);

    // R9 writes and reads ignored while busy
    write_byte(11'h400, 8'h5A);
    for (int i = 0; i < WIN + 20 && !busy; i++) @(negedge clk);
    check("R9", busy, 1);
    write_byte(11'h480, 8'hC3);
    addr = 11'h400; cs_n = 0; oe_n = 0; we_n = 1; #1;
    check("R9", rd_valid, 0);
    cs_n = 1; oe_n = 1;
    while (busy) @(negedge clk);
    idle(WIN + PROG + 10);
    check("R9", busy, 0);
    read_chk("R9", 11'h480, 8'hFF);
    read_chk("R9", 11'h400, 8'h5A);

    // R10 strobe with output enable low is not a write
    @(negedge clk);
    addr = 11'h500; wdata = 8'h66; cs_n = 0; we_n = 0; oe_n = 0;
    idle(2);
    cs_n = 1; we_n = 1; oe_n = 1;
    rose = 0;
    for (int i = 0; i < WIN + 10; i++) begin
      @(negedge clk);
      if (busy) rose = 1;
    end
    check("R10", rose, 0);
    read_chk("R10", 11'h500, 8'hFF);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule